// File: doc/BRIEF.md
# Vertical Countdown with Window Search

This block makes the vertical drive pulse of a video timing chain. It counts half-line ticks from a horizontal timebase that runs at twice the line rate, and it restarts its field count on incoming vertical sync pulses. A counting integrator screens the raw vertical sync level first, so short serrated pulses do not disturb the timing. When no sync arrives, the block runs on its own, so a field pulse is always produced.

Two window modes decide when a sync may restart the field. While the block is unsynchronised it uses a wide search window. After a run of sync pulses at exactly the nominal field length it moves to a narrow lock window around that nominal count. In that mode a missing sync is bridged by a forced restart at the far edge of the window. A sync that lands outside the window is ignored. A run of missing syncs, or a single non-standard field length, sends the block back to search mode. A select input picks the 50 Hz standard (625 half-lines per field) or the 60 Hz standard (525 half-lines per field). The block reports the current mode on its lock output and drives a vertical pulse of fixed width.

Top module: `vert_countdown`

## Requirements
- R1: A synchronous active-high reset puts the block in search mode with the half-line counter at zero, and marks the next field as free-running. During reset and on the first cycle after it, `field_start`, `vout` and `locked` are all 0.
- R2: With no sync and `locked`=0, a free-running field restarts after exactly 625 ticks when `std_60`=0 and after exactly 525 ticks when `std_60`=1.
- R3: The integrator produces a sync event only when `vs_in` has stayed high for INTEG_LEN consecutive clocks (default 4). Pulses shorter than that cause no restart. The event is acted on at the next tick.
- R4: The elapsed count e of a field is the number of ticks since the last restart, including the current one. In search mode, after a field that a sync started, a sync restarts the field only when 488 ≤ e ≤ 722; an earlier sync is ignored, and with no accepted sync the field ends at e=722. After a field that was free-running or forced, the first sync is accepted at any e.
- R5: In search mode, a qualifying sync is one whose e equals the nominal count (625 or 525) and whose field was itself started by a sync. When 16 qualifying syncs arrive in a row, `locked` becomes 1. Any other restart clears this run.
- R6: A field length is non-standard when e lies between 622 and 628 ticks (50 Hz) or between 522 and 528 ticks (60 Hz) but differs from the nominal count. In lock mode, an accepted sync at such a length drops the block to search mode (`locked`=0).
- R7: In lock mode, only a sync with e within nominal ±WIN (default 2) restarts the field. A sync outside that window has no effect on the field timing.
- R8: In lock mode with no sync inside the window, the field is restarted by force at e = nominal + WIN (627 for 50 Hz).
- R9: Six forced restarts in a row in lock mode return the block to search mode; `locked` falls at the 6th of them. A sync accepted inside the window resets this count.
- R10: `vout` rises together with `field_start` at every restart and stays high for PW ticks (default 12).
- R11: The half-line counter advances only on clocks where `tick` is 1. With `tick` high every other clock, a free-running 60 Hz field spans 1050 clocks.
- R12: `field_start` is a single-cycle registered pulse, one per restart. `locked` changes only on a cycle where `field_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Half-line tick enable (twice the line rate) |
| std_60 | input | 1 | 0 selects the 50 Hz standard, 1 selects the 60 Hz standard |
| vs_in | input | 1 | Raw vertical sync level, active high |
| vout | output | 1 | Vertical drive pulse |
| field_start | output | 1 | One-cycle pulse at each field restart |
| locked | output | 1 | 1 while the narrow lock window is in use |

## Verification
A rise on `vs_in` that is held long enough completes the integrator on the 4th rising edge. The field restarts on the 5th rising edge, given a tick there, and `field_start`, `vout` and `locked` show the result right after that edge. The bench places each sync pulse a chosen number of clocks after the last `field_start` it saw, with the lead adjusted for that five-edge path. It samples all outputs on falling edges. Most checks compare the spacing between successive `field_start` pulses, which the fixed latency does not shift, and read `locked` only after the restart that is due to change it.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
  typedef enum logic {
    MODE_SEARCH = 1'b0,
    MODE_LOCK   = 1'b1
  } vmode_t;
endpackage

// File: rtl/vcd_sync_integ.sv
// Counting integrator: an event only after LEN clocks of sustained sync level.
module vcd_sync_integ #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic vs_in,
  output logic evt
);
  localparam int IW = $clog2(LEN + 1);

  logic [IW-1:0] ic;
  logic          hit_q;
  logic          full;

  assign full = (ic == IW'(LEN));
  assign evt  = full & ~hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ic    <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= full;
      if (!vs_in)    ic <= '0;
      else if (!full) ic <= ic + 1'b1;
    end
  end
endmodule

// File: rtl/vcd_field_ctrl.sv
// Half-line counter with the search / lock window state machine.
module vcd_field_ctrl
  import vcd_pkg::*;
#(
  parameter int NOM50       = 625,
  parameter int NOM60       = 525,
  parameter int LINES50_LO  = 311,
  parameter int LINES50_HI  = 314,
  parameter int LINES60_LO  = 261,
  parameter int LINES60_HI  = 264,
  parameter int SRCH_LO     = 488,
  parameter int SRCH_HI     = 722,
  parameter int WIN         = 2,
  parameter int LOCK_N      = 16,
  parameter int MISS_N      = 6,
  parameter int CW          = $clog2(SRCH_HI + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          std_60,
  input  logic          sync_evt,
  output logic          restart,
  output logic          fs_q,
  output vmode_t        mode,
  output logic [CW-1:0] cnt
);
  localparam int GW = $clog2(LOCK_N);
  localparam int MW = $clog2(MISS_N);
  localparam logic [CW-1:0] T_NOM50  = CW'(NOM50);
  localparam logic [CW-1:0] T_NOM60  = CW'(NOM60);
  localparam logic [CW-1:0] T_NS50LO = CW'(2 * LINES50_LO);
  localparam logic [CW-1:0] T_NS50HI = CW'(2 * LINES50_HI);
  localparam logic [CW-1:0] T_NS60LO = CW'(2 * LINES60_LO);
  localparam logic [CW-1:0] T_NS60HI = CW'(2 * LINES60_HI);
  localparam logic [CW-1:0] T_SLO    = CW'(SRCH_LO);
  localparam logic [CW-1:0] T_SHI    = CW'(SRCH_HI);
  localparam logic [CW-1:0] T_WIN    = CW'(WIN);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_N - 1);
  localparam logic [MW-1:0] MISS_LAST = MW'(MISS_N - 1);

  logic [CW-1:0] e, nom, ns_lo, ns_hi, win_lo, win_hi;
  logic [GW-1:0] good;
  logic [MW-1:0] miss;
  logic          free_q, pend_q, pend_now;
  logic          in_win, in_band, is_nom, srch_ok, take, end_cond;

  always_comb begin
    e        = cnt + 1'b1;
    nom      = std_60 ? T_NOM60  : T_NOM50;
    ns_lo    = std_60 ? T_NS60LO : T_NS50LO;
    ns_hi    = std_60 ? T_NS60HI : T_NS50HI;
    win_lo   = nom - T_WIN;
    win_hi   = nom + T_WIN;
    pend_now = pend_q | sync_evt;
    in_win   = (e >= win_lo) && (e <= win_hi);
    in_band  = (e >= ns_lo) && (e <= ns_hi);
    is_nom   = (e == nom);
    srch_ok  = free_q || ((e >= T_SLO) && (e <= T_SHI));
    take     = pend_now && ((mode == MODE_LOCK) ? in_win : srch_ok);
    if (mode == MODE_LOCK) end_cond = (e >= win_hi);
    else if (free_q)       end_cond = (e >= nom);
    else                   end_cond = (e >= T_SHI);
    restart  = tick && (take || end_cond);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mode   <= MODE_SEARCH;
      free_q <= 1'b1;
      good   <= '0;
      miss   <= '0;
      pend_q <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      fs_q <= restart;
      if (tick)          pend_q <= 1'b0;
      else if (sync_evt) pend_q <= 1'b1;

      if (restart)   cnt <= '0;
      else if (tick) cnt <= e;

      if (restart) begin
        if (take) begin
          free_q <= 1'b0;
          if (mode == MODE_SEARCH) begin
            if (!free_q && is_nom) begin
              if (good == GOOD_LAST) begin
                mode <= MODE_LOCK;
                good <= '0;
                miss <= '0;
              end else begin
                good <= good + 1'b1;
              end
            end else begin
              good <= '0;
            end
          end else if (in_band && !is_nom) begin
            mode <= MODE_SEARCH;
            good <= '0;
            miss <= '0;
          end else begin
            miss <= '0;
          end
        end else begin
          free_q <= 1'b1;
          if (mode == MODE_SEARCH) begin
            good <= '0;
          end else if (miss == MISS_LAST) begin
            mode <= MODE_SEARCH;
            good <= '0;
            miss <= '0;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vcd_vpulse.sv
// Fixed-width vertical drive pulse, width counted in ticks.
module vcd_vpulse #(
  parameter int PW = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  output logic vout
);
  localparam int PWW = $clog2(PW + 1);
  localparam logic [PWW-1:0] PW_LAST = PWW'(PW - 1);

  logic [PWW-1:0] pw;

  always_ff @(posedge clk) begin
    if (rst) begin
      pw   <= '0;
      vout <= 1'b0;
    end else if (restart) begin
      pw   <= PW_LAST;
      vout <= 1'b1;
    end else if (tick) begin
      if (pw != '0) pw <= pw - 1'b1;
      else          vout <= 1'b0;
    end
  end
endmodule

// File: rtl/vert_countdown.sv
module vert_countdown
  import vcd_pkg::*;
#(
  parameter int NOM50      = 625,
  parameter int NOM60      = 525,
  parameter int LINES50_LO = 311,
  parameter int LINES50_HI = 314,
  parameter int LINES60_LO = 261,
  parameter int LINES60_HI = 264,
  parameter int SRCH_LO    = 488,
  parameter int SRCH_HI    = 722,
  parameter int WIN        = 2,
  parameter int LOCK_N     = 16,
  parameter int MISS_N     = 6,
  parameter int PW         = 12,
  parameter int INTEG_LEN  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic std_60,
  input  logic vs_in,
  output logic vout,
  output logic field_start,
  output logic locked
);
  localparam int CW = $clog2(SRCH_HI + 1);

  logic          sync_evt;
  logic          restart;
  vmode_t        mode;
  logic [CW-1:0] cnt_w;

  vcd_sync_integ #(.LEN(INTEG_LEN)) u_integ (
    .clk   (clk),
    .rst   (rst),
    .vs_in (vs_in),
    .evt   (sync_evt)
  );

  vcd_field_ctrl #(
    .NOM50(NOM50), .NOM60(NOM60),
    .LINES50_LO(LINES50_LO), .LINES50_HI(LINES50_HI),
    .LINES60_LO(LINES60_LO), .LINES60_HI(LINES60_HI),
    .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI), .WIN(WIN),
    .LOCK_N(LOCK_N), .MISS_N(MISS_N), .CW(CW)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .std_60   (std_60),
    .sync_evt (sync_evt),
    .restart  (restart),
    .fs_q     (field_start),
    .mode     (mode),
    .cnt      (cnt_w)
  );

  vcd_vpulse #(.PW(PW)) u_vpulse (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .restart (restart),
    .vout    (vout)
  );

  assign locked = (mode == MODE_LOCK);
endmodule

// File: rtl/vert_countdown_chk.sv
module vert_countdown_chk #(
  parameter int CW      = 10,
  parameter int SRCH_HI = 722
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          field_start,
  input logic          vout,
  input logic          locked,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] T_SHI = CW'(SRCH_HI);

  a_r12_fs_needs_tick: assert property (@(posedge clk) disable iff (rst)
    field_start |-> $past(tick));

  a_r10_vout_with_fs: assert property (@(posedge clk) disable iff (rst)
    field_start |-> vout);

  a_r12_lock_moves_with_fs: assert property (@(posedge clk) disable iff (rst)
    (locked != $past(locked)) |-> field_start);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < T_SHI);

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick)) |-> $stable(cnt));
endmodule

bind vert_countdown vert_countdown_chk #(.CW(CW), .SRCH_HI(SRCH_HI)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .field_start (field_start),
  .vout        (vout),
  .locked      (locked),
  .cnt         (cnt_w)
);

// File: tb/vert_countdown_tb.sv
module vert_countdown_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  // columns: std_60, sync spacing, sync count, expected spacing, expected locked
  localparam int NV = 7;
  localparam int TBL [NV][5] = '{
    '{0, 625, 16, 625, 0},   // R5 15 qualifying: not yet
    '{0, 625,  1, 625, 1},   // R5 16th qualifying: lock
    '{0, 626,  1, 626, 0},   // R6 non-standard drops lock
    '{0, 700,  3, 700, 0},   // R4 inside wide window
    '{0, 624,  5, 624, 0},   // R6 non-standard never counts
    '{1, 525, 16, 525, 1},   // R5 60 Hz lock
    '{1, 524,  1, 524, 0}    // R6 60 Hz non-standard
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic std_60 = 1'b0;
  logic vs_in = 1'b0;
  logic vout, field_start, locked;

  int cyc = 0;
  int last_fs = 0;
  int last_int = 0;
  int fs_count = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit tick_div = 1'b0;

  vert_countdown u_dut (
    .clk(clk), .rst(rst), .tick(tick), .std_60(std_60), .vs_in(vs_in),
    .vout(vout), .field_start(field_start), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (field_start) begin
      last_int = cyc - last_fs;
      last_fs  = cyc;
      fs_count = fs_count + 1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      tick = tick_div ? ~tick : 1'b1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_fields(input int n);
    int t;
    t = fs_count + n;
    while (fs_count < t) @(negedge clk);
  endtask

  // sync processed at elapsed count e relative to the last observed restart
  task automatic sync_at(input int e, input int hold);
    int base;
    base = last_fs;
    while (cyc < base + e - 5) @(negedge clk);
    vs_in = 1'b1;
    while (cyc < base + e - 5 + hold) @(negedge clk);
    vs_in = 1'b0;
    while (cyc < base + e + 3) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int fs_hi;
    int vw;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 vout in reset", vout, 0);
    check("R1 locked in reset", locked, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 field_start after reset", field_start, 0);
    check("R1 vout after reset", vout, 0);

    // R2 free run 50 Hz
    wait_fields(2);
    check("R2 free run 50", last_int, 625);

    // table walk
    for (int i = 0; i < NV; i++) begin
      std_60 = TBL[i][0][0];
      for (int k = 0; k < TBL[i][2]; k++) sync_at(TBL[i][1], 8);
      check($sformatf("R5/R6/R4 vec %0d spacing", i), last_int, TBL[i][3]);
      check($sformatf("R5/R6 vec %0d locked", i), locked, TBL[i][4]);
    end

    // lock again at 50 Hz
    std_60 = 1'b0;
    for (int k = 0; k < 17; k++) sync_at(625, 8);
    check("R5 lock 50", locked, 1);

    // R7 out-of-window sync ignored, R8 forced at 627
    sync_at(300, 8);
    wait_fields(1);
    check("R7 spacing after stray sync", last_int, 627);
    check("R8 still locked", locked, 1);

    // R9 count cleared by in-window sync
    wait_fields(4);
    check("R9 locked after 5 misses", locked, 1);
    sync_at(625, 8);
    check("R9 in-window sync spacing", last_int, 625);
    wait_fields(5);
    check("R9 locked after cleared + 5", locked, 1);
    check("R8 forced spacing", last_int, 627);
    wait_fields(1);
    check("R9 lost at 6th miss", locked, 0);
    wait_fields(1);
    check("R2 free run after loss", last_int, 625);

    // R3 serrations ignored
    begin
      int base;
      base = last_fs;
      while (cyc < base + 300) begin
        vs_in = 1'b1;
        repeat (3) @(negedge clk);
        vs_in = 1'b0;
        repeat (6) @(negedge clk);
      end
    end
    wait_fields(1);
    check("R3 serration rejected", last_int, 625);

    // R3 minimum-length pulse accepted, R4 any e after free field
    sync_at(100, 4);
    check("R3/R4 short field after free", last_int, 100);

    // R4 early sync ignored, field ends at 722
    sync_at(400, 8);
    wait_fields(1);
    check("R4 early ignored, end 722", last_int, 722);
    wait_fields(1);
    check("R2 free after 722", last_int, 625);

    // R10 vout width, R12 single-cycle field_start
    while (!field_start) @(negedge clk);
    vw = 0;
    fs_hi = 0;
    while (vout) begin
      vw++;
      if (field_start) fs_hi++;
      @(negedge clk);
    end
    check("R10 vout width", vw, 12);
    check("R12 field_start one cycle", fs_hi, 1);

    // R2 60 Hz free run
    std_60 = 1'b1;
    wait_fields(2);
    check("R2 free run 60", last_int, 525);

    // R11 tick every other clock
    tick_div = 1'b1;
    wait_fields(2);
    check("R11 tick gated spacing", last_int, 1050);
    tick_div = 1'b0;

    // R1 reset mid-run
    while (!vout) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 vout cleared", vout, 0);
    check("R1 field_start cleared", field_start, 0);
    check("R1 locked cleared", locked, 0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule